// File: doc/BRIEF.md
# Sample DMA CPU Stall Unit

This block decides who owns the bus in a cycle: the CPU read that is waiting, or a sample fetch that the audio DMA has asked for. A DMA request that arrives while the unit is idle starts a countdown of `STALL` cycles. A DMA fetch cycle follows the countdown. A CPU read that is present during the countdown or the fetch cycle is held off. While it is held off, the unit puts dummy reads of the CPU's pending address on the bus. After the fetch cycle the held read completes normally.

Dummy reads use the CPU cycle parity. In the countdown cycles before the last one, a dummy read goes out only on odd cycles. The last countdown cycle always issues one, whatever the parity. The two serial controller input ports lose bits on every access, so for those addresses every dummy read is suppressed except the one in the last countdown cycle. As a result, each port sees exactly one extra read. CPU writes are never held off, and they never cause dummy reads. The fetch datapath and the audio channel sit outside this block.

Top module: `dma_stall_unit`

## Requirements
- R1: Out of reset no DMA is pending. A CPU read presented after reset completes in the same cycle (`cpu_stall`=0, `cpu_rvalid`=1), and `dma_go` is 0.
- R2: A `dma_req` accepted while idle in cycle C0 makes a CPU read present in cycles C0+1 through C0+STALL+1 see `cpu_stall`=1 and `cpu_rvalid`=0.
- R3: `dma_go` is high for exactly one cycle, cycle C0+STALL+1. That is the fetch cycle, and `bus_rd` is 0 in it.
- R4: For addresses other than the two input ports, in countdown cycles C0+1 through C0+STALL-1, a stalled read drives `bus_rd` = `cpu_cycle_odd` (1 means an odd cycle), with `bus_addr` = `cpu_addr`.
- R5: In the last countdown cycle, C0+STALL, a stalled read always drives `bus_rd`=1 to `cpu_addr`, even when `cpu_cycle_odd`=0.
- R6: For `cpu_addr` equal to PORT_A (0x4016) or PORT_B (0x4017), a stalled read drives `bus_rd`=0 in every countdown cycle except C0+STALL, whatever the parity.
- R7: In cycle C0+STALL+2 the held read completes with `cpu_rvalid`=1, `bus_rd`=1, `bus_addr`=`cpu_addr` and `cpu_rdata`=`bus_rdata`.
- R8: A CPU write during a pending DMA passes straight to the bus (`bus_wr`=1, same address and data). It raises no stall and no `bus_rd`.
- R9: A `dma_req` that arrives while a DMA is already pending is ignored. The stall and `dma_go` timing stay those of the first request.

Ports are listed in port-list order in the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_req | input | 1 | CPU read request, held until `cpu_rvalid` |
| cpu_wr_req | input | 1 | CPU write request |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_cycle_odd | input | 1 | Low bit of the CPU cycle counter (1 = odd cycle) |
| dma_req | input | 1 | Sample DMA fetch request |
| bus_rdata | input | DW | Bus read data |
| cpu_stall | output | 1 | CPU read held off this cycle |
| cpu_rvalid | output | 1 | CPU read completes this cycle |
| cpu_rdata | output | DW | CPU read data |
| bus_rd | output | 1 | Bus read strobe (real or dummy) |
| bus_wr | output | 1 | Bus write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| dma_go | output | 1 | DMA fetch cycle |

## Verification
The hardest case to reach is the last countdown cycle on an even CPU cycle. In that cycle parity alone would forbid a dummy read, yet a read must still go out, and for the input ports it must be the only one. The bench reaches it by pulsing `dma_req` while idle, holding a read from the next cycle on, and driving `cpu_cycle_odd` from a chosen per-cycle pattern that forces parity low in the final countdown cycle. It runs this with both port addresses and with ordinary addresses, and it runs it once more with a second `dma_req` injected mid-stall.

// File: rtl/dma_stall_unit.sv
module dma_stall_unit #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int STALL = 4,
  parameter logic [AW-1:0] PORT_A = 16'h4016,
  parameter logic [AW-1:0] PORT_B = 16'h4017
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd_req,
  input  logic          cpu_wr_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_cycle_odd,
  input  logic          dma_req,
  input  logic [DW-1:0] bus_rdata,
  output logic          cpu_stall,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          dma_go
);
  localparam int CW = $clog2(STALL + 1);

  logic [CW-1:0] cnt;
  logic          go;
  logic          pending, last, port, dummy_ok;

  assign pending  = (cnt != '0) | go;
  assign last     = (cnt == CW'(1));
  assign port     = (cpu_addr == PORT_A) | (cpu_addr == PORT_B);
  assign dummy_ok = last | (~port & cpu_cycle_odd & (cnt != '0));

  assign cpu_stall  = cpu_rd_req & pending;
  assign cpu_rvalid = cpu_rd_req & ~pending;
  assign cpu_rdata  = bus_rdata;
  assign bus_rd     = cpu_rd_req & (~pending | dummy_ok);
  assign bus_wr     = cpu_wr_req;
  assign bus_addr   = cpu_addr;
  assign bus_wdata  = cpu_wdata;
  assign dma_go     = go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      go  <= 1'b0;
    end else begin
      go <= last;
      if (dma_req && !pending) cnt <= CW'(STALL);
      else if (cnt != '0)      cnt <= cnt - CW'(1);
    end
  end

  a_r9_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));
  a_r3_fetch_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dma_go |-> (cnt == '0) && !bus_rd && !cpu_rvalid);
  a_r6_port_single_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && bus_rd && port) |-> last);
  a_r5_final_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && last) |-> bus_rd);
  a_r7_complete_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> bus_rd && !cpu_stall);
  a_r8_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_req && !cpu_rd_req) |-> !bus_rd && !cpu_stall);
  a_r2_stall_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_stall, cpu_rvalid}));
endmodule

// File: tb/dma_stall_unit_bench.sv
module dma_stall_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd_req = 1'b0, cpu_wr_req = 1'b0, cpu_cycle_odd = 1'b0, dma_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, bus_rdata = 8'hA5;
  logic        cpu_stall, cpu_rvalid, bus_rd, bus_wr, dma_go;
  logic [7:0]  cpu_rdata, bus_wdata;
  logic [15:0] bus_addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dma_stall_unit u_dma_stall_unit (
    .clk(clk), .rst_n(rst_n), .cpu_rd_req(cpu_rd_req), .cpu_wr_req(cpu_wr_req),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_cycle_odd(cpu_cycle_odd),
    .dma_req(dma_req), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dma_go(dma_go));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic test_reset;
    @(negedge clk) cpu_rd_req = 1'b1; cpu_addr = 16'h0123; #1;
    check("R1 stall after reset", cpu_stall, 0);
    check("R1 rvalid after reset", cpu_rvalid, 1);
    check("R1 dma_go after reset", dma_go, 0);
    check("R1 rdata", cpu_rdata, 8'hA5);
    @(negedge clk) cpu_rd_req = 1'b0;
  endtask

  task automatic stall_read(input logic [15:0] a, input logic [2:0] par, input bit again, input string tag);
    logic exp_rd;
    logic is_port;
    is_port = (a == 16'h4016) || (a == 16'h4017);
    @(negedge clk) dma_req = 1'b1; cpu_rd_req = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      dma_req = again && (k == 2);
      cpu_rd_req = 1'b1; cpu_addr = a;
      cpu_cycle_odd = (k <= 3) ? par[k-1] : 1'b0;
      bus_rdata = 8'h30 + 8'(k);
      #1;
      if (k <= 3)      exp_rd = is_port ? 1'b0 : par[k-1];
      else if (k == 5) exp_rd = 1'b0;
      else             exp_rd = 1'b1;
      check($sformatf("%s R2 stall k=%0d", tag, k), cpu_stall, k <= 5);
      check($sformatf("%s R3 dma_go k=%0d", tag, k), dma_go, k == 5);
      if (k <= 3) check($sformatf("%s %s bus_rd k=%0d", tag, is_port ? "R6" : "R4", k), bus_rd, exp_rd);
      else if (k == 4) check($sformatf("%s R5 final dummy", tag), bus_rd, 1);
      else if (k == 5) check($sformatf("%s R3 fetch quiet", tag), bus_rd, 0);
      else begin
        check($sformatf("%s R7 rvalid", tag), cpu_rvalid, 1);
        check($sformatf("%s R7 bus_rd", tag), bus_rd, 1);
        check($sformatf("%s R7 rdata", tag), cpu_rdata, 8'h36);
      end
      if (exp_rd) check($sformatf("%s R4 addr k=%0d", tag, k), bus_addr, a);
      if (again && k >= 2) check($sformatf("%s R9 timing k=%0d", tag, k), dma_go, k == 5);
    end
    @(negedge clk) cpu_rd_req = 1'b0; cpu_cycle_odd = 1'b0;
  endtask

  task automatic write_during_dma;
    @(negedge clk) dma_req = 1'b1;
    @(negedge clk) dma_req = 1'b0; cpu_wr_req = 1'b1; cpu_addr = 16'h4016;
    cpu_wdata = 8'h5C; cpu_cycle_odd = 1'b1; #1;
    check("R8 bus_wr", bus_wr, 1);
    check("R8 addr", bus_addr, 16'h4016);
    check("R8 wdata", bus_wdata, 8'h5C);
    check("R8 no bus_rd", bus_rd, 0);
    check("R8 no stall", cpu_stall, 0);
    @(negedge clk) cpu_wr_req = 1'b0; cpu_cycle_odd = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    stall_read(16'h2007, 3'b101, 1'b0, "plain odd-even");
    stall_read(16'h2007, 3'b010, 1'b0, "plain even-odd");
    stall_read(16'h4016, 3'b111, 1'b0, "port A");
    stall_read(16'h4017, 3'b101, 1'b0, "port B");
    stall_read(16'h0200, 3'b011, 1'b1, "re-request");
    write_during_dma();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule